// File: doc/BRIEF.md
# Round-Robin SPI ADC Scanner

This block is an SPI master that keeps polling an external eight-input, 10-bit successive-approximation converter without any command from the host. It visits the inputs in a fixed circular order. For each input it runs one conversion: it selects the converter, clocks out a 32-bit command made of two 16-bit words, and collects the 32 bits that come back. It keeps only the 10-bit result and stores it in a small bank of readings, one entry per input.

The host reads the bank through a simple read port with one cycle of latency. A one-cycle update strobe, which carries the input index, reports each new reading. The chip-select setup time, the hold guard after the last bit and the idle gap between conversions are all counted in system clocks and set by parameters. The serial clock is the system clock divided by a parameter.

Top module: `adc_rr_scanner`

## Requirements
- R1: After reset release, the first conversion is for input 0. Each completed conversion moves the scan from input n to input (n+1) mod 8, so input 7 is followed by input 0.
- R2: Each conversion shifts out 32 bits on `mosi`, MSB first. The first 16-bit word is 16'h0001. In the second word, bit 15 is 1, bits 14:12 hold the input number and all other bits are 0.
- R3: The two received words are joined with the first word in the upper half. The stored reading is bits 9:0 of that 32-bit stream, zero-extended to 16 bits. Bits 31:10 have no effect on the reading.
- R4: `cs_n` is low for at least SETUP_CYC system clocks before the first rising edge of `sck` in a conversion.
- R5: After the last falling edge of `sck` in a conversion, `cs_n` stays low for at least GUARD_CYC system clocks before it goes high.
- R6: Between two conversions, `cs_n` stays high for exactly GAP_CYC system clocks.
- R7: `sck` uses SPI mode 0. It is low whenever `cs_n` is high. Each period is SCK_DIV system clocks, with the high phase lasting SCK_DIV/2 clocks. Exactly 32 rising edges occur in each select window. `miso` is sampled on the rising edge.
- R8: While reset is asserted and after it is released, every stored reading is 16'hFFFF until its first conversion completes. During reset, `cs_n` is high and `sck` and `upd_valid` are low.
- R9: `rd_data` shows the reading for the `rd_addr` presented one cycle earlier. If that same cycle also wrote that entry, `rd_data` shows the new value. `upd_valid` is high for exactly one cycle per conversion, with `upd_ch` set to the input that was written. It appears in the same cycle that the new value first shows on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Serial command data to the converter |
| miso | input | 1 | Serial result data from the converter |
| cs_n | output | 1 | Active-low converter select |
| rd_addr | input | 3 | Input index to read |
| rd_data | output | 16 | Stored reading, one cycle after `rd_addr` |
| upd_valid | output | 1 | One-cycle strobe when a reading is written |
| upd_ch | output | 3 | Input index of the reading just written |

## Verification
A wrong scan index shows up in two places within one conversion, about 730 clocks. The channel field of the command on `mosi` is wrong, and `upd_ch` jumps out of sequence at the next strobe. A miscounted bit or divider counter changes the number of `sck` rising edges or the period length, and this is visible when `cs_n` next rises. An error in the bank or its bypass path shows a mismatch on `rd_data` one cycle after the address is presented. The bench aims about half of its reads at the entry being converted, so it exercises write-and-read collisions on most updates.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;
  typedef enum logic [1:0] {
    ST_SETUP,
    ST_XFER,
    ST_GUARD,
    ST_GAP
  } scan_state_t;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/adc_rr_shifter.sv
// Mode-0 shift engine: one start pulse runs XFER_BITS clocks, MSB first.
// Only the last RX_W received bits are kept, which are the low bits of the stream.
module adc_rr_shifter #(
  parameter int SCK_DIV   = 16,
  parameter int XFER_BITS = 32,
  parameter int RX_W      = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [XFER_BITS-1:0] tx_word,
  input  logic                 miso,
  output logic                 sck,
  output logic                 mosi,
  output logic                 done,
  output logic [RX_W-1:0]      rx_word
);
  localparam int HALF  = SCK_DIV / 2;
  localparam int DIV_W = $clog2(SCK_DIV);
  localparam int BIT_W = $clog2(XFER_BITS);

  logic                 busy;
  logic [DIV_W-1:0]     div_q;
  logic [BIT_W-1:0]     bit_q;
  logic [XFER_BITS-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      tx_q    <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          div_q <= '0;
          bit_q <= '0;
          mosi  <= tx_word[XFER_BITS-1];
          tx_q  <= {tx_word[XFER_BITS-2:0], 1'b0};
        end
      end else begin
        if (div_q == DIV_W'(SCK_DIV - 1)) div_q <= '0;
        else                              div_q <= div_q + 1'b1;
        // rising edge: sample the converter
        if (div_q == DIV_W'(HALF - 1)) begin
          sck     <= 1'b1;
          rx_word <= {rx_word[RX_W-2:0], miso};
        end
        // falling edge: present next command bit or finish
        if (div_q == DIV_W'(SCK_DIV - 1)) begin
          sck <= 1'b0;
          if (bit_q == BIT_W'(XFER_BITS - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            mosi <= 1'b0;
          end else begin
            bit_q <= bit_q + 1'b1;
            mosi  <= tx_q[XFER_BITS-1];
            tx_q  <= {tx_q[XFER_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_rr_seq.sv
// Select sequencer: setup -> transfer -> guard -> idle gap, then the next input.
module adc_rr_seq
  import adc_rr_pkg::*;
#(
  parameter int CH_NUM    = 8,
  parameter int SETUP_CYC = 13,
  parameter int GUARD_CYC = 12,
  parameter int GAP_CYC   = 180
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      done,
  output logic                      start,
  output logic                      cs_n,
  output logic [$clog2(CH_NUM)-1:0] ch
);
  localparam int CH_W  = $clog2(CH_NUM);
  localparam int MAXC  = max3(SETUP_CYC, GUARD_CYC, GAP_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  scan_state_t      state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      // leave reset at the end of a gap so scanning starts with no command
      state <= ST_GAP;
      cnt   <= CNT_W'(GAP_CYC - 1);
      cs_n  <= 1'b1;
      start <= 1'b0;
      ch    <= '0;
    end else begin
      start <= 1'b0;
      unique case (state)
        ST_SETUP: begin
          if (cnt == CNT_W'(SETUP_CYC - 1)) begin
            state <= ST_XFER;
            start <= 1'b1;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_XFER: begin
          if (done) begin
            state <= ST_GUARD;
            cnt   <= '0;
          end
        end
        ST_GUARD: begin
          if (cnt == CNT_W'(GUARD_CYC - 1)) begin
            state <= ST_GAP;
            cs_n  <= 1'b1;
            cnt   <= '0;
            ch    <= (ch == CH_W'(CH_NUM - 1)) ? '0 : ch + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_GAP: begin
          if (cnt == CNT_W'(GAP_CYC - 1)) begin
            state <= ST_SETUP;
            cs_n  <= 1'b0;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_GAP;
      endcase
    end
  end
endmodule

// File: rtl/adc_rr_bank.sv
// Reading bank with registered, write-first read port and update strobe.
module adc_rr_bank #(
  parameter int                 CH_NUM   = 8,
  parameter int                 DATA_W   = 16,
  parameter logic [DATA_W-1:0]  INIT_VAL = '1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [$clog2(CH_NUM)-1:0] wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [$clog2(CH_NUM)-1:0] rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      upd_valid,
  output logic [$clog2(CH_NUM)-1:0] upd_ch
);
  logic [DATA_W-1:0] mem [CH_NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CH_NUM; i++) mem[i] <= INIT_VAL;
      rd_data   <= INIT_VAL;
      upd_valid <= 1'b0;
      upd_ch    <= '0;
    end else begin
      upd_valid <= wr_en;
      if (wr_en) begin
        mem[wr_addr] <= wr_data;
        upd_ch       <= wr_addr;
      end
      rd_data <= (wr_en && (wr_addr == rd_addr)) ? wr_data : mem[rd_addr];
    end
  end
endmodule

// File: rtl/adc_rr_scanner.sv
module adc_rr_scanner #(
  parameter int CH_NUM    = 8,
  parameter int RES_W     = 10,
  parameter int FRAME_W   = 16,
  parameter int DATA_W    = 16,
  parameter int SCK_DIV   = 16,
  parameter int SETUP_CYC = 13,
  parameter int GUARD_CYC = 12,
  parameter int GAP_CYC   = 180
) (
  input  logic                      clk,
  input  logic                      rst,
  output logic                      sck,
  output logic                      mosi,
  input  logic                      miso,
  output logic                      cs_n,
  input  logic [$clog2(CH_NUM)-1:0] rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      upd_valid,
  output logic [$clog2(CH_NUM)-1:0] upd_ch
);
  localparam int CH_W      = $clog2(CH_NUM);
  localparam int XFER_BITS = 2 * FRAME_W;
  localparam int PAD_W     = FRAME_W - 1 - CH_W;

  logic                 start;
  logic                 done;
  logic [CH_W-1:0]      ch;
  logic [XFER_BITS-1:0] cmd;
  logic [RES_W-1:0]     result;
  logic [DATA_W-1:0]    wr_data;

  // first word carries the start bit in its LSB; second: single-ended flag + input number
  assign cmd     = {FRAME_W'(1), 1'b1, ch, {PAD_W{1'b0}}};
  assign wr_data = {{(DATA_W - RES_W){1'b0}}, result};

  adc_rr_seq #(
    .CH_NUM(CH_NUM), .SETUP_CYC(SETUP_CYC), .GUARD_CYC(GUARD_CYC), .GAP_CYC(GAP_CYC)
  ) seq_i (
    .clk(clk), .rst(rst), .done(done), .start(start), .cs_n(cs_n), .ch(ch)
  );

  adc_rr_shifter #(
    .SCK_DIV(SCK_DIV), .XFER_BITS(XFER_BITS), .RX_W(RES_W)
  ) shf_i (
    .clk(clk), .rst(rst), .start(start), .tx_word(cmd), .miso(miso),
    .sck(sck), .mosi(mosi), .done(done), .rx_word(result)
  );

  adc_rr_bank #(
    .CH_NUM(CH_NUM), .DATA_W(DATA_W), .INIT_VAL('1)
  ) bank_i (
    .clk(clk), .rst(rst), .wr_en(done), .wr_addr(ch), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .upd_valid(upd_valid), .upd_ch(upd_ch)
  );
endmodule

// File: rtl/adc_rr_checker.sv
module adc_rr_checker #(
  parameter int CH_NUM    = 8,
  parameter int SCK_DIV   = 16,
  parameter int SETUP_CYC = 13,
  parameter int GUARD_CYC = 12,
  parameter int GAP_CYC   = 180
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      sck,
  input logic                      cs_n,
  input logic                      upd_valid,
  input logic [$clog2(CH_NUM)-1:0] upd_ch
);
  localparam int CH_W = $clog2(CH_NUM);
  localparam int CW   = $clog2(GAP_CYC + SETUP_CYC + GUARD_CYC + 64 * SCK_DIV + 4);

  logic [CW-1:0]   lo_cnt, hi_cnt, fall_cnt;
  logic            prev_cs, seen_rise, have_ch;
  logic [CH_W-1:0] last_ch, next_ch;

  assign next_ch = (last_ch == CH_W'(CH_NUM - 1)) ? '0 : last_ch + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0; hi_cnt <= '0; fall_cnt <= '0;
      prev_cs <= 1'b1; seen_rise <= 1'b0; have_ch <= 1'b0; last_ch <= '0;
    end else begin
      prev_cs  <= cs_n;
      lo_cnt   <= cs_n ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt   <= !cs_n ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
      fall_cnt <= sck ? '0 : ((fall_cnt == '1) ? fall_cnt : fall_cnt + 1'b1);
      if (!prev_cs && cs_n) seen_rise <= 1'b1;
      if (upd_valid) begin
        have_ch <= 1'b1;
        last_ch <= upd_ch;
      end
    end
  end

  p_first_ch_r1: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !have_ch) |-> (upd_ch == '0));
  p_rr_order_r1: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && have_ch) |-> (upd_ch == next_ch));
  p_cs_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> (lo_cnt >= CW'(SETUP_CYC)));
  p_cs_guard_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (fall_cnt >= CW'(GUARD_CYC)));
  p_gap_len_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && seen_rise) |-> (hi_cnt == CW'(GAP_CYC)));
  p_sck_idle_r7: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  p_upd_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> !upd_valid);
endmodule

bind adc_rr_scanner adc_rr_checker #(
  .CH_NUM(CH_NUM), .SCK_DIV(SCK_DIV), .SETUP_CYC(SETUP_CYC),
  .GUARD_CYC(GUARD_CYC), .GAP_CYC(GAP_CYC)
) chk_i (
  .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .upd_valid(upd_valid), .upd_ch(upd_ch)
);

// File: tb/adc_rr_scanner_tb_top.sv
module adc_rr_scanner_tb_top;
  localparam int SCK_DIV = 16, SETUP = 13, GUARD = 12, GAP = 180, N_UPD = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic sck, mosi, miso, cs_n, upd_valid;
  logic [2:0]  rd_addr = '0, upd_ch;
  logic [15:0] rd_data;
  always #4 clk = ~clk;

  adc_rr_scanner #(.SCK_DIV(SCK_DIV), .SETUP_CYC(SETUP), .GUARD_CYC(GUARD), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .rd_addr(rd_addr), .rd_data(rd_data), .upd_valid(upd_valid), .upd_ch(upd_ch));

  int checks = 0, errors = 0, upd_seen = 0, adc_seq = 0, pend_ch = 0;
  bit finished = 0;
  logic [31:0] adc_tx = '0, adc_rx = '0;
  bit adc_act = 0;
  logic [9:0]  pend_val = '0;
  logic [15:0] model [8];

  function automatic logic [31:0] exp_cmd(int ch);
    return {16'h0001, 1'b1, 3'(ch), 12'h000};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural converter: undriven high bits modelled as random junk
  assign miso = adc_tx[31];
  always @(negedge cs_n) begin
    logic [21:0] junk;
    pend_ch = adc_seq % 8;
    junk = 22'($urandom);
    if (adc_seq == 0)      begin junk = '1; pend_val = 10'h000; end
    else if (adc_seq == 1) begin junk = '0; pend_val = 10'h3FF; end
    else if (adc_seq == 2) begin junk = 22'h2AAAAA; pend_val = 10'h155; end
    else pend_val = 10'($urandom);
    adc_tx = {junk, pend_val};
    adc_rx = '0;
    adc_act = 1;
    adc_seq++;
  end
  always @(negedge sck) if (adc_act) adc_tx = adc_tx << 1;
  always @(posedge sck) if (adc_act) adc_rx = {adc_rx[30:0], mosi};
  always @(posedge cs_n) if (adc_act) begin
    adc_act = 0;
    chk(adc_rx == exp_cmd(pend_ch), "R2", "command stream", adc_rx, exp_cmd(pend_ch));
  end

  // port monitor state
  int cyc = 0, fall_cyc = 0, last_rise = 0, last_fall = 0, rises = 0, hi_len = 0;
  bit prev_cs = 1, prev_sck = 0, gap_seen = 0, prev_upd = 0;

  task automatic step(int idx);
    cyc++;
    if (prev_cs && !cs_n) begin
      if (gap_seen) chk(hi_len == GAP, "R6", "gap length", hi_len, GAP);
      fall_cyc = cyc; rises = 0;
    end
    if (!prev_cs && cs_n) begin
      chk(rises == 32, "R7", "rising edges per window", rises, 32);
      chk(cyc - last_fall >= GUARD, "R5", "hold guard", cyc - last_fall, GUARD);
      chk(sck == 1'b0, "R7", "sck idle", sck, 0);
      hi_len = 0; gap_seen = 1;
    end
    if (cs_n) hi_len++;
    if (!prev_sck && sck) begin
      if (rises == 0) chk(cyc - fall_cyc >= SETUP, "R4", "select setup", cyc - fall_cyc, SETUP);
      else chk(cyc - last_rise == SCK_DIV, "R7", "sck period", cyc - last_rise, SCK_DIV);
      rises++; last_rise = cyc;
    end
    if (prev_sck && !sck) begin
      chk(cyc - last_rise == SCK_DIV / 2, "R7", "sck high phase", cyc - last_rise, SCK_DIV / 2);
      last_fall = cyc;
    end
    if (upd_valid) begin
      chk(upd_ch == 3'(pend_ch), "R1", "scan order", upd_ch, pend_ch);
      chk(!prev_upd, "R9", "strobe width", prev_upd, 0);
      model[upd_ch] = {6'b0, pend_val};
      upd_seen++;
    end
    if (upd_valid && rd_addr == upd_ch)
      chk(rd_data == model[rd_addr], "R3", "fresh reading", rd_data, model[rd_addr]);
    else if (model[rd_addr] == 16'hFFFF)
      chk(rd_data == model[rd_addr], "R8", "unconverted reading", rd_data, model[rd_addr]);
    else
      chk(rd_data == model[rd_addr], "R9", "read port", rd_data, model[rd_addr]);
    prev_cs = cs_n; prev_sck = sck; prev_upd = upd_valid;
    // next read address: directed sweep first, then biased toward the active input
    if (idx < 8) rd_addr = 3'(idx);
    else if ($urandom % 2 == 0) rd_addr = 3'(pend_ch);
    else rd_addr = 3'($urandom);
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 8; i++) model[i] = 16'hFFFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 1'b1, "R8", "cs_n in reset", cs_n, 1);
    chk(sck == 1'b0, "R8", "sck in reset", sck, 0);
    chk(upd_valid == 1'b0, "R8", "strobe in reset", upd_valid, 0);
    chk(rd_data == 16'hFFFF, "R8", "reading in reset", rd_data, 16'hFFFF);
    rst = 1'b0;
    for (int i = 0; upd_seen < N_UPD; i++) begin
      @(negedge clk);
      step(i);
    end
    chk(upd_seen == N_UPD, "R1", "update count", upd_seen, N_UPD);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual %0d updates expected %0d", upd_seen, N_UPD);
    report();
  end
endmodule